// File: doc/BRIEF.md
# Per-Processor Interrupt Interface

This block is the slice of a multiprocessor interrupt controller that belongs to one processor. It collects that processor's private sources and the shared sources already routed to it, and it holds an enable bit and an in-service ("active") bit for every interrupt ID. Software turns single interrupts on and off by writing an ID to a set-enable or a clear-enable location. It finds out what to service by reading a ready location, which returns the chosen ID. It ends servicing by writing that ID to a completion location. While the interface is switched on, one request line tells the core that work is waiting.

IDs below 32 are private to the processor. Each has a 2-bit trigger code, and the codes are packed sixteen to a 32-bit word. IDs 0 to 15 can also be raised in software by other processors. Any processor can raise one by writing a signal word that holds a target-processor mask and an ID. The block turns that write into a one-cycle pulse vector toward the targets, which other processors' interfaces receive on their software-interrupt inputs. Shared IDs start at 32 and arrive as level requests that were conditioned upstream.

Top module: `ciu_cpu_if`

## Requirements
- R1: After reset the interface is off, every enable, active bit and latch is clear, all trigger codes are 0, `irq_o` is low, `ipi_o` is zero and `rdata` is zero.
- R2: A write to word address 4 loads the ID from `wdata[9:0]` and sets the enable of that ID only. An ID of 64 or more changes nothing. Data bits above the ID field are ignored.
- R3: A write to word address 5 loads the ID from `wdata[9:0]` and clears the enable of that ID only. An ID of 64 or more changes nothing.
- R4: Word address 1 holds the trigger codes of IDs 0-15 and word address 2 holds those of IDs 16-31. ID i sits at bits [2*(i%16)+1 : 2*(i%16)]. Both words are written and read back whole.
- R5: Trigger code 0 makes a private ID pending while its line is high, and code 1 while its line is low. Code 2 latches a rising edge and code 3 latches a falling edge. A latch stays pending until the ID is taken by a ready read.
- R6: Shared ID 32+k is pending while `shared_i[k]` is high.
- R7: A read of word address 6 returns, one clock later on `rdata`, the lowest ID that is pending, enabled and not active. That ID becomes active and its latch is cleared. If no ID qualifies, the read returns 0x3FF and changes nothing.
- R8: A write to word address 7 loads the ID from `wdata[9:0]` and clears the active bit of that ID. Writing an ID that is not active changes nothing.
- R9: `irq_o` is high exactly when bit 0 of word address 0 is set and at least one ID is pending, enabled and not active. It follows level lines in the same cycle.
- R10: A write to word address 8 drives `ipi_o` with `wdata[8 +: NUM_CPU]` and `ipi_id_o` with `wdata[3:0]` on the next cycle. `ipi_o` is zero in every other cycle, and `ipi_id_o` holds its last value.
- R11: A cycle with `sgi_i` high latches ID `sgi_id_i` (0-15) as pending, whatever that ID's trigger code is. A new event that arrives in the same cycle as the ID is taken wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| priv_i | input | 32 | Private source lines, IDs 0-31 |
| shared_i | input | NUM_SHARED | Shared level requests routed to this processor |
| sgi_i | input | 1 | Incoming software interrupt strobe |
| sgi_id_i | input | 4 | ID of the incoming software interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| ipi_o | output | NUM_CPU | One-cycle target pulse of a signal write |
| ipi_id_o | output | 4 | ID carried with the last signal write |

## Verification
`irq_o` is combinational from state and level lines. It moves in the same cycle as a level line or shared request. It moves one clock edge after an edge, a software strobe, an enable or completion write, or a ready read. `rdata` and `ipi_o` are registered and change on the first edge after the access. The bench drives inputs on the falling edge and updates its reference model on the rising edge. It compares all four outputs one nanosecond after every falling edge, so each output is checked in the first cycle it is due and in every cycle after.

// File: rtl/ciu_pkg.sv
package ciu_pkg;

   localparam int REG_W  = 32;
   localparam int PRIV_N = 32;
   localparam int SGI_N  = 16;
   localparam int AW     = 4;

   localparam logic [AW-1:0] A_CTRL    = 4'd0;
   localparam logic [AW-1:0] A_TRIG_LO = 4'd1;
   localparam logic [AW-1:0] A_TRIG_HI = 4'd2;
   localparam logic [AW-1:0] A_EN_SET  = 4'd4;
   localparam logic [AW-1:0] A_EN_CLR  = 4'd5;
   localparam logic [AW-1:0] A_READY   = 4'd6;
   localparam logic [AW-1:0] A_DONE    = 4'd7;
   localparam logic [AW-1:0] A_SIGNAL  = 4'd8;

   typedef enum logic [1:0] {
      TRG_LVL_HI = 2'd0,
      TRG_LVL_LO = 2'd1,
      TRG_RISE   = 2'd2,
      TRG_FALL   = 2'd3
   } trig_e;

endpackage

// File: rtl/ciu_src_cond.sv
module ciu_src_cond
   import ciu_pkg::*;
#(
   parameter int N       = 32,
   parameter int SW_N    = 16,
   parameter int SW_ID_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       line_i,
   input  logic [2*N-1:0]     trig_i,
   input  logic               sgi_vld_i,
   input  logic [SW_ID_W-1:0] sgi_id_i,
   input  logic [N-1:0]       ack_i,
   output logic [N-1:0]       pend_o
);

   if (SW_N > N) begin : g_bad_sw
      $error("software IDs exceed private range");
   end
   if ((1 << SW_ID_W) < SW_N) begin : g_bad_sw_w
      $error("software ID field too narrow");
   end

   for (genvar g = 0; g < N; g++) begin : g_src
      trig_e code;
      logic  prev_q;
      logic  lat_q;
      logic  edge_hit;
      logic  sw_hit;
      logic  lvl_hit;

      assign code = trig_e'(trig_i[2*g +: 2]);

      if (g < SW_N) begin : g_sw
         assign sw_hit = sgi_vld_i && (sgi_id_i == SW_ID_W'(g));
      end else begin : g_nosw
         assign sw_hit = 1'b0;
      end

      assign edge_hit = ((code == TRG_RISE) &&  line_i[g] && !prev_q) ||
                        ((code == TRG_FALL) && !line_i[g] &&  prev_q);
      assign lvl_hit  = ((code == TRG_LVL_HI) &&  line_i[g]) ||
                        ((code == TRG_LVL_LO) && !line_i[g]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            lat_q  <= 1'b0;
         end else begin
            prev_q <= line_i[g];
            if (edge_hit || sw_hit) lat_q <= 1'b1;
            else if (ack_i[g])      lat_q <= 1'b0;
         end
      end

      assign pend_o[g] = lvl_hit | lat_q;

      AST_RISE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
         (code == TRG_RISE && $rose(line_i[g])) |=> pend_o[g]); // R5
   end

endmodule

// File: rtl/ciu_find_first.sv
module ciu_find_first #(
   parameter int N  = 64,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   if (N < 2) begin : g_bad_n
      $error("search width too small");
   end

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
   end

   always_comb begin
      if (found_o) begin
         AST_LOWEST_WINS: assert ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0); // R7
      end
   end

endmodule

// File: rtl/ciu_ipi_gen.sv
module ciu_ipi_gen #(
   parameter int NUM_CPU = 4,
   parameter int ID_BITS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire_i,
   input  logic [NUM_CPU-1:0] mask_i,
   input  logic [ID_BITS-1:0] id_i,
   output logic [NUM_CPU-1:0] ipi_o,
   output logic [ID_BITS-1:0] ipi_id_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ipi_o    <= '0;
         ipi_id_o <= '0;
      end else begin
         ipi_o <= fire_i ? mask_i : '0;
         if (fire_i) ipi_id_o <= id_i;
      end
   end

   AST_IPI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_o != '0) |-> $past(fire_i)); // R10

   AST_IPI_ID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !fire_i |=> $stable(ipi_id_o)); // R10

endmodule

// File: rtl/ciu_cpu_if.sv
module ciu_cpu_if
   import ciu_pkg::*;
#(
   parameter int NUM_SHARED = 32,
   parameter int NUM_CPU    = 4,
   parameter int ID_W       = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [AW-1:0]         addr,
   input  logic [REG_W-1:0]      wdata,
   output logic [REG_W-1:0]      rdata,
   input  logic [PRIV_N-1:0]     priv_i,
   input  logic [NUM_SHARED-1:0] shared_i,
   input  logic                  sgi_i,
   input  logic [3:0]            sgi_id_i,
   output logic                  irq_o,
   output logic [NUM_CPU-1:0]    ipi_o,
   output logic [3:0]            ipi_id_o
);

   localparam int NUM_IRQ = PRIV_N + NUM_SHARED;
   localparam int IW      = $clog2(NUM_IRQ);
   localparam logic [ID_W-1:0] NONE_ID = '1;

   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("target mask field holds 1 to 8 processors");
   end
   if (NUM_SHARED < 1) begin : g_bad_shared
      $error("at least one shared source required");
   end
   if ((64'd1 << ID_W) <= 64'(NUM_IRQ) || ID_W > 16) begin : g_bad_idw
      $error("ID field must leave the all-ones code free");
   end

   logic                  ctrl_en_q;
   logic [2*PRIV_N-1:0]   trig_q;
   logic [NUM_IRQ-1:0]    en_q;
   logic [NUM_IRQ-1:0]    act_q;
   logic [REG_W-1:0]      rdata_q;

   logic [ID_W-1:0]       wr_id;
   logic [IW-1:0]         wr_idx;
   logic                  id_ok;
   logic [NUM_IRQ-1:0]    id_oh;
   logic [PRIV_N-1:0]     priv_pend;
   logic [NUM_IRQ-1:0]    pend;
   logic [NUM_IRQ-1:0]    elig;
   logic                  win_found;
   logic [IW-1:0]         win_idx;
   logic                  take;
   logic [NUM_IRQ-1:0]    take_oh;
   logic                  wr_set, wr_clr, wr_done, wr_sig;

   assign wr_id   = wdata[ID_W-1:0];
   assign wr_idx  = wr_id[IW-1:0];
   assign id_ok   = (wr_id < ID_W'(NUM_IRQ));
   assign id_oh   = id_ok ? (NUM_IRQ'(1) << wr_idx) : '0;

   assign wr_set  = wr_en && (addr == A_EN_SET);
   assign wr_clr  = wr_en && (addr == A_EN_CLR);
   assign wr_done = wr_en && (addr == A_DONE);
   assign wr_sig  = wr_en && (addr == A_SIGNAL);

   assign take    = rd_en && (addr == A_READY);
   assign take_oh = (take && win_found) ? (NUM_IRQ'(1) << win_idx) : '0;

   ciu_src_cond #(
      .N       (PRIV_N),
      .SW_N    (SGI_N),
      .SW_ID_W (4)
   ) i_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (priv_i),
      .trig_i    (trig_q),
      .sgi_vld_i (sgi_i),
      .sgi_id_i  (sgi_id_i),
      .ack_i     (take_oh[PRIV_N-1:0]),
      .pend_o    (priv_pend)
   );

   assign pend = {shared_i, priv_pend};
   assign elig = pend & en_q & ~act_q;

   ciu_find_first #(
      .N  (NUM_IRQ),
      .IW (IW)
   ) i_pick (
      .vec_i   (elig),
      .found_o (win_found),
      .idx_o   (win_idx)
   );

   ciu_ipi_gen #(
      .NUM_CPU (NUM_CPU),
      .ID_BITS (4)
   ) i_ipi (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (wr_sig),
      .mask_i   (wdata[8 +: NUM_CPU]),
      .id_i     (wdata[3:0]),
      .ipi_o    (ipi_o),
      .ipi_id_o (ipi_id_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en_q <= 1'b0;
         trig_q    <= '0;
         en_q      <= '0;
         act_q     <= '0;
      end else begin
         if (wr_en && addr == A_CTRL)    ctrl_en_q <= wdata[0];
         if (wr_en && addr == A_TRIG_LO) trig_q[REG_W-1:0] <= wdata;
         if (wr_en && addr == A_TRIG_HI) trig_q[2*REG_W-1:REG_W] <= wdata;
         en_q  <= (en_q | (wr_set ? id_oh : '0)) & ~(wr_clr ? id_oh : '0);
         act_q <= (act_q & ~(wr_done ? id_oh : '0)) | take_oh;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         unique case (addr)
            A_CTRL:    rdata_q <= {{(REG_W-1){1'b0}}, ctrl_en_q};
            A_TRIG_LO: rdata_q <= trig_q[REG_W-1:0];
            A_TRIG_HI: rdata_q <= trig_q[2*REG_W-1:REG_W];
            A_READY:   rdata_q <= REG_W'(win_found ? ID_W'(win_idx) : NONE_ID);
            default:   rdata_q <= '0;
         endcase
      end
   end

   assign rdata = rdata_q;
   assign irq_o = ctrl_en_q && (elig != '0);

   AST_ENSET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && id_ok) |=> en_q[$past(wr_idx)]); // R2

   AST_ENCLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && id_ok) |=> !en_q[$past(wr_idx)]); // R3

   AST_TAKE_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && win_found) |=> act_q[$past(win_idx)]); // R7

   AST_EMPTY_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !win_found) |=> (rdata == REG_W'(NONE_ID))); // R7

   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && id_ok && !(take && win_found && win_idx == wr_idx))
      |=> !act_q[$past(wr_idx)]); // R8

   AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CTRL && !wdata[0]) |=> !irq_o); // R9

endmodule

// File: tb/test_ciu_cpu_if.sv
`timescale 1ns/1ps
module test_ciu_cpu_if;

   localparam int NS   = 32;
   localparam int NCPU = 4;
   localparam int NIRQ = 32 + NS;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             rd_en = 1'b0;
   logic [3:0]       addr = '0;
   logic [31:0]      wdata = '0;
   logic [31:0]      rdata;
   logic [31:0]      priv_i = '0;
   logic [NS-1:0]    shared_i = '0;
   logic             sgi_i = 1'b0;
   logic [3:0]       sgi_id_i = '0;
   logic             irq_o;
   logic [NCPU-1:0]  ipi_o;
   logic [3:0]       ipi_id_o;

   always #2.5 clk = ~clk;

   ciu_cpu_if #(.NUM_SHARED(NS), .NUM_CPU(NCPU), .ID_W(10)) i_ciu_cpu_if (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .priv_i(priv_i), .shared_i(shared_i),
      .sgi_i(sgi_i), .sgi_id_i(sgi_id_i), .irq_o(irq_o), .ipi_o(ipi_o),
      .ipi_id_o(ipi_id_o)
   );

   int    checks = 0;
   int    errors = 0;
   bit    started = 1'b0;
   string cur_req = "R1";

   // reference model state
   bit              m_ctrl;
   logic [63:0]     m_trig;
   bit              m_en  [NIRQ];
   bit              m_act [NIRQ];
   bit              m_lat [32];
   bit              m_prev[32];
   bit              m_nlat[32];
   logic [31:0]     m_rdata;
   logic [NCPU-1:0] m_ipi;
   logic [3:0]      m_ipi_id;
   int              m_w;
   int              m_id;

   function automatic bit m_pend(int i);
      if (i < 32) begin
         bit lvl;
         case (m_trig[2*i +: 2])
            2'd0:    lvl = priv_i[i];
            2'd1:    lvl = !priv_i[i];
            default: lvl = 1'b0;
         endcase
         return lvl || m_lat[i];
      end
      return shared_i[i-32];
   endfunction

   function automatic int m_win();
      for (int i = 0; i < NIRQ; i++)
         if (m_pend(i) && m_en[i] && !m_act[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_trig = '0; m_rdata = '0; m_ipi = '0; m_ipi_id = '0;
         for (int i = 0; i < NIRQ; i++) begin m_en[i] = 0; m_act[i] = 0; end
         for (int i = 0; i < 32; i++) begin m_lat[i] = 0; m_prev[i] = 0; end
      end else begin
         m_w  = m_win();
         m_id = int'(wdata[9:0]);
         for (int i = 0; i < 32; i++) begin
            bit e;
            bit s;
            e = (m_trig[2*i +: 2] == 2'd2 && priv_i[i] && !m_prev[i]) ||
                (m_trig[2*i +: 2] == 2'd3 && !priv_i[i] && m_prev[i]);
            s = e || (i < 16 && sgi_i && int'(sgi_id_i) == i);
            if (s) m_nlat[i] = 1;
            else if (rd_en && addr == 4'd6 && m_w == i) m_nlat[i] = 0;
            else m_nlat[i] = m_lat[i];
         end
         if (rd_en) begin
            case (addr)
               4'd0:    m_rdata = {31'd0, m_ctrl};
               4'd1:    m_rdata = m_trig[31:0];
               4'd2:    m_rdata = m_trig[63:32];
               4'd6:    m_rdata = (m_w >= 0) ? 32'(m_w) : 32'h3FF;
               default: m_rdata = '0;
            endcase
         end
         if (wr_en && addr == 4'd7 && m_id < NIRQ) m_act[m_id] = 0;
         if (rd_en && addr == 4'd6 && m_w >= 0) m_act[m_w] = 1;
         if (wr_en && addr == 4'd0) m_ctrl = wdata[0];
         if (wr_en && addr == 4'd1) m_trig[31:0] = wdata;
         if (wr_en && addr == 4'd2) m_trig[63:32] = wdata;
         if (wr_en && addr == 4'd4 && m_id < NIRQ) m_en[m_id] = 1;
         if (wr_en && addr == 4'd5 && m_id < NIRQ) m_en[m_id] = 0;
         if (wr_en && addr == 4'd8) begin
            m_ipi = wdata[8 +: NCPU]; m_ipi_id = wdata[3:0];
         end else begin
            m_ipi = '0;
         end
         for (int i = 0; i < 32; i++) begin
            m_lat[i] = m_nlat[i]; m_prev[i] = priv_i[i];
         end
      end
   end

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (started) begin
         chk("irq_o (R9)", 32'(irq_o), 32'(m_ctrl && (m_win() >= 0)));
         chk("rdata", rdata, m_rdata);
         chk("ipi_o (R10)", 32'(ipi_o), 32'(m_ipi));
         chk("ipi_id_o (R10)", 32'(ipi_id_o), 32'(m_ipi_id));
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(logic [3:0] a);
      @(negedge clk); rd_en = 1; addr = a;
      @(negedge clk); rd_en = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      cur_req = "R1";
      @(posedge clk); @(posedge clk);
      started = 1;
      idle(2);
      rst_n = 1;
      idle(2);

      cur_req = "R7";              // empty ready read returns all ones
      rd(4'd6); idle(1);

      cur_req = "R4";              // packing: ID5 rise, ID17 rise, ID18 fall, ID20 level low
      wr(4'd0, 32'h1);
      wr(4'd1, 32'h0000_0800);
      wr(4'd2, 32'h0000_0138);
      rd(4'd1); rd(4'd2); rd(4'd0);

      cur_req = "R11";             // software interrupt on ID 15
      @(negedge clk); sgi_i = 1; sgi_id_i = 4'd15;
      @(negedge clk); sgi_i = 0;
      wr(4'd4, 32'd15);
      rd(4'd6);
      cur_req = "R8";
      wr(4'd7, 32'd15); idle(1);

      cur_req = "R5";              // rising latch on ID 17, re-raised while active
      wr(4'd4, 32'd17);
      @(negedge clk); priv_i[17] = 1;
      @(negedge clk); priv_i[17] = 0;
      idle(1);
      rd(4'd6);
      @(negedge clk); priv_i[17] = 1;
      @(negedge clk); priv_i[17] = 0;
      wr(4'd7, 32'd17);
      rd(4'd6); wr(4'd7, 32'd17);
      @(negedge clk); priv_i[18] = 1;   // falling mode ignores the rise
      idle(1);
      wr(4'd4, 32'd18);
      @(negedge clk); priv_i[18] = 0;
      idle(1);
      rd(4'd6); wr(4'd7, 32'd18);
      wr(4'd4, 32'd20);                 // level low, line low
      rd(4'd6);
      @(negedge clk); priv_i[20] = 1;
      wr(4'd7, 32'd20); idle(2);

      cur_req = "R6";              // shared 40 vs private 21, lowest first
      @(negedge clk); shared_i[8] = 1; priv_i[21] = 1;
      wr(4'd4, 32'd40); idle(1);
      wr(4'd4, 32'd21);
      cur_req = "R9";
      wr(4'd0, 32'h0); idle(1);
      wr(4'd0, 32'h1);
      cur_req = "R7";
      rd(4'd6); rd(4'd6); rd(4'd6);
      cur_req = "R8";
      wr(4'd7, 32'd3);             // not active: no effect
      wr(4'd7, 32'd40); wr(4'd7, 32'd21);

      cur_req = "R3";
      wr(4'd5, 32'd21); idle(1);
      wr(4'd5, 32'd40); idle(1);

      cur_req = "R2";              // out-of-range ID ignored, upper data bits ignored
      wr(4'd4, 32'd64); rd(4'd6);
      @(negedge clk); sgi_i = 1; sgi_id_i = 4'd5;
      @(negedge clk); sgi_i = 0;
      wr(4'd4, 32'h0000_0405);
      rd(4'd6); wr(4'd7, 32'd5);

      cur_req = "R11";             // new event on the cycle the ID is taken
      @(negedge clk); sgi_i = 1; sgi_id_i = 4'd5; rd_en = 1; addr = 4'd6;
      @(negedge clk); sgi_i = 0; rd_en = 0;
      wr(4'd7, 32'd5); rd(4'd6); wr(4'd7, 32'd5);

      cur_req = "R10";
      wr(4'd8, 32'h0000_A50F);
      wr(4'd8, 32'h0000_0302);
      idle(3);

      finish_run();
   end

endmodule